// File: doc/BRIEF.md
# Channel Fault Latch and Status Encoder

This block holds the diagnostic logic of one channel of an inductive-load low-side driver. It receives raw fault flags from the analog comparators: short circuit, overtemperature, power-ground loss, clock loss, open load in the off state, open load in the on state, signal-ground loss and supply loss. It synchronizes each flag and filters it digitally with a short or a long filter. From the filtered flags it keeps two memories. An error register, cleared only by a hold timer, keeps every error visible for a minimum time. A shutdown latch turns the power stage off after a destructive fault.

The commanded state is enable AND input. Enable and input are taken as synchronous to `clk`, which is the slow diagnostic clock (one cycle is about 4 µs). The status bit matches the commanded state when the channel is healthy and is inverted while any error is shown. The gate-enable drives the power stage. It is on only when the channel is commanded on, the shutdown latch is clear and the clock is present. A regulated-channel select shortens the low time that releases the latch, because a regulated channel is driven by PWM.

Top module: `chan_diag_top`

## Requirements
- R1: While `rst_n` is low, and after it is released with no fault flag set, `gate_o` and `status_o` are both 0 when `en_i` or `in_i` is low.
- R2: With no error, `status_o` equals `en_i & in_i` and `gate_o` equals `en_i & in_i`. Both follow the inputs in the same cycle.
- R3: While the error register, the shutdown latch or the synchronized clock-loss flag is set, `status_o` is the inverse of `en_i & in_i`.
- R4: Every raw flag passes two synchronizer flops. Short circuit, overtemperature and on-state open load must then stay qualified for SHORT_LEN (default 2) consecutive cycles before they count as an error. A shorter pulse restarts the count and has no effect.
- R5: Off-state open load, power-ground loss, signal-ground loss and supply loss need LONG_LEN (default 8) consecutive qualified cycles. A shorter pulse has no effect.
- R6: Once a filtered error goes away, the error register stays set for HOLD_CYC (default 256) more cycles.
- R7: A filtered short circuit, overtemperature or power-ground loss, or a synchronized clock loss, sets the shutdown latch only while `en_i & in_i` is high. While the latch is set, `gate_o` is 0.
- R8: The shutdown latch clears only after `en_i & in_i` has been low for STD_LOW (default 256) consecutive cycles, or REG_LOW (default 132) cycles when `regulated_i` is 1. A shorter low phase leaves it set.
- R9: Signal-ground loss and supply loss invert the status but never set the shutdown latch. `gate_o` stays on during and after them.
- R10: Off-state open load is qualified only while `en_i & in_i` is low. On-state open load, short circuit, signal-ground loss and supply loss are qualified only while it is high.
- R11: A synchronized clock-loss flag, without any filter, forces `gate_o` to 0 and inverts `status_o` for as long as it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Diagnostic clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| in_i | input | 1 | Channel control input |
| regulated_i | input | 1 | 1 selects the regulated-channel latch release time |
| short_i | input | 1 | Raw short-circuit flag |
| hot_i | input | 1 | Raw overtemperature flag |
| pgnd_loss_i | input | 1 | Raw power-ground loss flag |
| clk_loss_i | input | 1 | Raw clock-loss flag |
| open_off_i | input | 1 | Raw open-load flag, off-state comparator |
| open_on_i | input | 1 | Raw open-load flag, on-state undercurrent comparator |
| sgnd_loss_i | input | 1 | Raw signal-ground loss flag |
| supply_loss_i | input | 1 | Raw supply loss flag |
| gate_o | output | 1 | Power stage enable |
| status_o | output | 1 | Diagnostic status bit |

## Verification
The bench drives each fault flag twice. A pulse just shorter than its filter shows that the filter restarts. A pulse long enough to pass shows that the error registers. Each flag is also applied with the channel on and with it off, which separates the on-state and off-state qualification and separates the faults that latch from those that only invert the status. The latch is released once with a low phase shorter than the release time and once with a longer one, for both channel types. This separates a PWM gap from a real reset. A cycle-based reference model runs alongside and compares gate and status on every clock, so off-by-one errors in the hold and release counts are caught.

// File: rtl/diag_pkg.sv
package diag_pkg;

   localparam int NUM_FLT = 7;

   // fault slot numbers; the clock-loss flag rides in slot NUM_FLT
   localparam int F_SHORT    = 0;
   localparam int F_HOT      = 1;
   localparam int F_PGND     = 2;
   localparam int F_OPEN_ON  = 3;
   localparam int F_OPEN_OFF = 4;
   localparam int F_SGND     = 5;
   localparam int F_SUPPLY   = 6;

   // qualification kinds
   localparam int Q_ANY = 0;
   localparam int Q_ON  = 1;
   localparam int Q_OFF = 2;

   function automatic logic uses_long(int idx);
      return (idx == F_PGND) || (idx == F_OPEN_OFF) ||
             (idx == F_SGND) || (idx == F_SUPPLY);
   endfunction

   function automatic int qual_of(int idx);
      if (idx == F_OPEN_OFF)
         return Q_OFF;
      if (idx == F_HOT || idx == F_PGND)
         return Q_ANY;
      return Q_ON;
   endfunction

   function automatic logic trips_latch(int idx);
      return (idx == F_SHORT) || (idx == F_HOT) || (idx == F_PGND);
   endfunction

endpackage

// File: rtl/diag_sync.sv
module diag_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   initial begin
      assert (STAGES >= 2) else $error("diag_sync: STAGES must be at least 2");
      assert (W >= 1) else $error("diag_sync: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++)
            stg[s] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int s = 1; s < STAGES; s++)
            stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/diag_filter.sv
module diag_filter #(
   parameter int LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic q_i,
   output logic flt_o
);

   localparam int CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] LEN_V = CW'(LEN);

   initial begin
      assert (LEN >= 1) else $error("diag_filter: LEN must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!q_i)
         cnt_q <= '0;
      else if (cnt_q != LEN_V)
         cnt_q <= cnt_q + 1'b1;
   end

   assign flt_o = (cnt_q == LEN_V);

   // R4/R5: the filter output can only rise after a qualified input cycle
   a_r4_rise_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_o) |-> $past(q_i));

   // R5: a dropped input always clears the filter on the next cycle
   a_r5_drop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      !q_i |=> !flt_o || (LEN_V == CW'(0)));

endmodule

// File: rtl/diag_hold.sv
module diag_hold #(
   parameter int HOLD = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   output logic err_o
);

   localparam int HW = $clog2(HOLD + 1);
   localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

   initial begin
      assert (HOLD >= 1) else $error("diag_hold: HOLD must be at least 1");
   end

   logic [HW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         err_o  <= 1'b0;
      end else if (active_i) begin
         left_q <= HOLD_V;
         err_o  <= 1'b1;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
         if (left_q == HW'(1))
            err_o <= 1'b0;
      end
   end

   // R6: an active error is registered on the next edge
   a_r6_error_captured: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |=> err_o);

   // R6: the register never drops while an error is still present
   a_r6_no_early_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_o) |-> $past(!active_i));

endmodule

// File: rtl/diag_fail_latch.sv
module diag_fail_latch #(
   parameter int STD_LOW = 256,
   parameter int REG_LOW = 132
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_i,
   input  logic trip_i,
   input  logic slow_i,
   output logic fail_o
);

   localparam int MAXT = (STD_LOW > REG_LOW) ? STD_LOW : REG_LOW;
   localparam int LW   = $clog2(MAXT + 2);
   localparam logic [LW-1:0] STD_V = LW'(STD_LOW);
   localparam logic [LW-1:0] REG_V = LW'(REG_LOW);

   initial begin
      assert (STD_LOW >= 1 && REG_LOW >= 1)
         else $error("diag_fail_latch: release times must be positive");
   end

   logic [LW-1:0] low_q;
   logic [LW-1:0] low_nxt;
   logic [LW-1:0] tsel;

   assign tsel    = slow_i ? REG_V : STD_V;
   assign low_nxt = (low_q < tsel) ? low_q + 1'b1 : low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= '0;
         fail_o <= 1'b0;
      end else if (cmd_i) begin
         low_q <= '0;
         if (trip_i)
            fail_o <= 1'b1;
      end else begin
         low_q <= low_nxt;
         if (low_nxt >= tsel)
            fail_o <= 1'b0;
      end
   end

   // R7: the latch is only set from the on state by a trip request
   a_r7_set_only_on: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_o) |-> $past(cmd_i && trip_i));

   // R8: a low phase shorter than the release time keeps the latch
   a_r8_short_low_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_o && !cmd_i && (low_nxt < tsel)) |=> fail_o);

   // R8: the latch clears only while the command is low
   a_r8_clear_when_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fail_o) |-> $past(!cmd_i));

endmodule

// File: rtl/chan_diag_top.sv
module chan_diag_top
   import diag_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SHORT_LEN   = 2,
   parameter int LONG_LEN    = 8,
   parameter int HOLD_CYC    = 256,
   parameter int STD_LOW     = 256,
   parameter int REG_LOW     = 132
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic in_i,
   input  logic regulated_i,
   input  logic short_i,
   input  logic hot_i,
   input  logic pgnd_loss_i,
   input  logic clk_loss_i,
   input  logic open_off_i,
   input  logic open_on_i,
   input  logic sgnd_loss_i,
   input  logic supply_loss_i,
   output logic gate_o,
   output logic status_o
);

   localparam int RAW_W = NUM_FLT + 1;

   initial begin
      assert (LONG_LEN >= SHORT_LEN)
         else $error("chan_diag_top: long filter shorter than short filter");
   end

   logic               cmd;
   logic [RAW_W-1:0]   raw;
   logic [RAW_W-1:0]   syn;
   logic [NUM_FLT-1:0] flt;
   logic [NUM_FLT-1:0] trip;
   logic               clk_lost;
   logic               err_q;
   logic               fail_q;
   logic               any_err;

   assign cmd = en_i & in_i;

   assign raw[F_SHORT]    = short_i;
   assign raw[F_HOT]      = hot_i;
   assign raw[F_PGND]     = pgnd_loss_i;
   assign raw[F_OPEN_ON]  = open_on_i;
   assign raw[F_OPEN_OFF] = open_off_i;
   assign raw[F_SGND]     = sgnd_loss_i;
   assign raw[F_SUPPLY]   = supply_loss_i;
   assign raw[NUM_FLT]    = clk_loss_i;

   diag_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (syn)
   );

   assign clk_lost = syn[NUM_FLT];

   for (genvar i = 0; i < NUM_FLT; i++) begin : g_flt
      localparam int LEN = uses_long(i) ? LONG_LEN : SHORT_LEN;
      localparam int QK  = qual_of(i);
      logic qual;

      if (QK == Q_ON) begin : g_on
         assign qual = cmd;
      end else if (QK == Q_OFF) begin : g_off
         assign qual = ~cmd;
      end else begin : g_any
         assign qual = 1'b1;
      end

      diag_filter #(.LEN(LEN)) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .q_i   (syn[i] & qual),
         .flt_o (flt[i])
      );

      if (trips_latch(i)) begin : g_trip
         assign trip[i] = flt[i];
      end else begin : g_notrip
         assign trip[i] = 1'b0;
      end
   end

   diag_hold #(.HOLD(HOLD_CYC)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i ((|flt) | clk_lost),
      .err_o    (err_q)
   );

   diag_fail_latch #(.STD_LOW(STD_LOW), .REG_LOW(REG_LOW)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_i  (cmd),
      .trip_i ((|trip) | clk_lost),
      .slow_i (regulated_i),
      .fail_o (fail_q)
   );

   assign any_err  = err_q | fail_q | clk_lost;
   assign gate_o   = cmd & ~fail_q & ~clk_lost;
   assign status_o = cmd ^ any_err;

   // R7: a trip seen in the on state closes the gate on the next cycle
   a_r7_trip_closes_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd && (|trip)) |=> !gate_o);

   // R11: clock loss always shows as an error and blocks the gate
   a_r11_clock_loss_flags: assert property (@(posedge clk) disable iff (!rst_n)
      clk_lost |-> (!gate_o && (status_o != cmd)));

   // R9: ground or supply loss alone never trips the latch
   a_r9_no_trip_from_supply: assert property (@(posedge clk) disable iff (!rst_n)
      (!fail_q && !clk_lost && ((flt & ~(flt & trip)) == flt)
       && (flt[F_SGND] || flt[F_SUPPLY]) && trip == '0) |=> !$rose(fail_q));

endmodule

// File: tb/chan_diag_top_test.sv
module chan_diag_top_test;

   localparam int SHORT = 2;
   localparam int LONG  = 8;
   localparam int HOLD  = 256;
   localparam int TSTD  = 256;
   localparam int TREG  = 132;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, in = 1'b0, regd = 1'b0;
   logic [7:0] raw = 8'h00; // 0 short,1 hot,2 pgnd,3 open_on,4 open_off,5 sgnd,6 supply,7 clk loss
   logic gate, status;

   int nchk = 0;
   int nfail = 0;
   string phase = "R1 reset";
   bit done = 1'b0;

   always #2 clk = ~clk;

   chan_diag_top uut (
      .clk(clk), .rst_n(rst_n), .en_i(en), .in_i(in), .regulated_i(regd),
      .short_i(raw[0]), .hot_i(raw[1]), .pgnd_loss_i(raw[2]), .clk_loss_i(raw[7]),
      .open_off_i(raw[4]), .open_on_i(raw[3]), .sgnd_loss_i(raw[5]),
      .supply_loss_i(raw[6]), .gate_o(gate), .status_o(status)
   );

   // ---------------- reference model ----------------
   bit m_s1 [8];
   bit m_s2 [8];
   int m_cnt [7];
   int m_hold = 0;
   bit m_err = 0;
   bit m_fail = 0;
   int m_low = 0;

   function automatic int flen(int i);
      return (i == 0 || i == 1 || i == 3) ? SHORT : LONG;
   endfunction

   function automatic bit fqual(int i, bit c);
      if (i == 4) return !c;
      if (i == 1 || i == 2) return 1'b1;
      return c;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin m_s1[i] = 0; m_s2[i] = 0; end
         for (int i = 0; i < 7; i++) m_cnt[i] = 0;
         m_hold = 0; m_err = 0; m_fail = 0; m_low = 0;
      end else begin
         bit c, act, trip;
         int t;
         c = en & in;
         act = m_s2[7];
         trip = m_s2[7];
         for (int i = 0; i < 7; i++) begin
            if (m_cnt[i] == flen(i)) begin
               act = 1;
               if (i <= 2) trip = 1;
            end
         end
         if (act) begin
            m_hold = HOLD; m_err = 1;
         end else if (m_hold > 0) begin
            if (m_hold == 1) m_err = 0;
            m_hold--;
         end
         t = regd ? TREG : TSTD;
         if (c) begin
            m_low = 0;
            if (trip) m_fail = 1;
         end else begin
            if (m_low < t) m_low++;
            if (m_low >= t) m_fail = 0;
         end
         for (int i = 0; i < 7; i++) begin
            if (m_s2[i] && fqual(i, c))
               m_cnt[i] = (m_cnt[i] < flen(i)) ? m_cnt[i] + 1 : m_cnt[i];
            else
               m_cnt[i] = 0;
         end
         for (int i = 0; i < 8; i++) begin m_s2[i] = m_s1[i]; m_s1[i] = raw[i]; end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         bit c, eg, es;
         c  = en & in;
         eg = c & !m_fail & !m_s2[7];
         es = c ^ (m_err | m_fail | m_s2[7]);
         nchk++;
         if (gate !== eg || status !== es) begin
            nfail++;
            $display("FAIL %s model compare: gate=%b status=%b expected gate=%b status=%b at %0t",
                     phase, gate, status, eg, es, $time);
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic act, logic exp);
      @(negedge clk);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
      @(posedge clk);
      #1;
   endtask

   task automatic pulse(int bitn, int n);
      raw[bitn] = 1'b1;
      tick(n);
      raw[bitn] = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired (all requirements) actual running expected finished");
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      tick(3);
      chk("R1 gate in reset", gate, 1'b0);
      chk("R1 status in reset", status, 1'b0);
      rst_n = 1'b1;
      tick(4);
      chk("R1 status after reset", status, 1'b0);

      phase = "R2 command patterns";
      en = 1; in = 1; tick(5);
      chk("R2 status on", status, 1'b1);
      chk("R2 gate on", gate, 1'b1);
      in = 0; tick(5);
      chk("R2 status en only", status, 1'b0);
      en = 0; in = 1; tick(5);
      chk("R2 gate in only", gate, 1'b0);

      phase = "R4 short filter";
      en = 1; in = 1; tick(3);
      pulse(0, 1); tick(6);
      chk("R4 one-cycle short ignored", status, 1'b1);
      pulse(0, 3); tick(4);
      chk("R7 short latches gate off", gate, 1'b0);
      chk("R3 status inverted when on", status, 1'b0);

      phase = "R8 standard release";
      in = 0; tick(20);
      chk("R3 status inverted when off", status, 1'b1);
      tick(30);
      in = 1; tick(2);
      chk("R8 short low keeps latch", gate, 1'b0);
      in = 0; tick(300);
      in = 1; tick(2);
      chk("R8 long low releases latch", gate, 1'b1);
      chk("R8 status healthy", status, 1'b1);

      phase = "R8 regulated release";
      regd = 1; tick(3);
      pulse(1, 3); tick(10);
      in = 0; tick(100);
      in = 1; tick(2);
      chk("R8 regulated short low keeps latch", gate, 1'b0);
      in = 0; tick(140);
      in = 1; tick(2);
      chk("R8 regulated release after 132", gate, 1'b1);
      chk("R6 error still held", status, 1'b0);
      tick(20);
      chk("R6 hold expired", status, 1'b1);
      regd = 0;

      phase = "R5 long filter";
      pulse(2, 5); tick(10);
      chk("R5 short ground-loss pulse ignored", status, 1'b1);
      pulse(2, 12); tick(3);
      chk("R5 long ground-loss latches", gate, 1'b0);
      in = 0; tick(300);
      in = 1; tick(3);

      phase = "R9 signal ground and supply";
      raw[5] = 1; tick(15);
      chk("R9 signal-ground loss inverts", status, 1'b0);
      chk("R9 gate stays on", gate, 1'b1);
      raw[5] = 0; tick(5);
      chk("R6 hold after release", status, 1'b0);
      tick(300);
      chk("R6 hold released", status, 1'b1);
      pulse(6, 20); tick(3);
      chk("R9 supply loss keeps gate", gate, 1'b1);
      tick(300);

      phase = "R10 open-load qualification";
      pulse(4, 20); tick(3);
      chk("R10 off-state open ignored when on", status, 1'b1);
      en = 0; raw[4] = 1; tick(15);
      chk("R10 off-state open seen when off", status, 1'b1);
      chk("R10 gate off", gate, 1'b0);
      raw[4] = 0; tick(300);
      chk("R10 off status clean", status, 1'b0);
      pulse(3, 20); tick(3);
      chk("R10 on-state open ignored when off", status, 1'b0);
      en = 1; raw[3] = 1; tick(15);
      chk("R10 on-state open seen when on", status, 1'b0);
      chk("R10 on-state open keeps gate", gate, 1'b1);
      raw[3] = 0; tick(300);

      phase = "R11 clock loss";
      raw[7] = 1; tick(3);
      chk("R11 gate off on clock loss", gate, 1'b0);
      chk("R11 status inverted on clock loss", status, 1'b0);
      raw[7] = 0; tick(5);
      chk("R7 clock loss latched", gate, 1'b0);
      in = 0; tick(300);
      raw[7] = 1; tick(3);
      chk("R11 status inverted while off", status, 1'b1);
      raw[7] = 0; tick(300);
      chk("R11 status clean after return", status, 1'b0);
      in = 1; tick(3);
      chk("R2 back to normal", gate, 1'b1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule